// File: doc/BRIEF.md
# GPIO Input Interrupt Controller

This block is the input half of a 32-pin general-purpose I/O unit. Each pad input is asynchronous to the clock. It first passes through a two-stage synchronizer. A stability filter follows, switched on or off per pin. The filter lets a new level through only once that level has persisted long enough. The settled pin levels are presented as an input data word, and they are also the only thing the interrupt logic looks at.

Each pin can flag an interrupt on four conditions: a rising edge, a falling edge, a high level, or a low level. Each condition has its own 32-bit enable mask. Pending conditions collect in a per-pin state register. Software clears a state bit by writing a one to it. A test register lets software set state bits directly. A per-pin enable gates each state bit onto the interrupt output. A single-cycle write strobe with a 3-bit address programs all the controls.

Top module: `gpin_irq_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `data_in_o`, `intr_state_o` and `irq_o` are all zero. All control registers and filter counters reset to zero.
- R2: For a pin whose filter is disabled, `data_in_o` shows the pad level that was applied before the third rising clock edge (two synchronizer stages plus the settled register).
- R3: For a pin whose filter is enabled (address 0), a synchronized level that differs from the settled value is accepted only after it has been seen on `FILTER_CYCLES` consecutive clocks. A shorter pulse leaves `data_in_o` unchanged.
- R4: When a pin's bit is set in the rising mask (address 1), a 0-to-1 change of its settled value sets its state bit on the next edge.
- R5: When a pin's bit is set in the falling mask (address 2), a 1-to-0 change of its settled value sets its state bit on the next edge.
- R6: When a pin's bit is set in the high mask (address 3), every cycle in which the settled value is 1 sets its state bit.
- R7: When a pin's bit is set in the low mask (address 4), every cycle in which the settled value is 0 sets its state bit.
- R8: Writing the state register (address 6) clears each state bit written as 1 and leaves bits written as 0 unchanged.
- R9: Writing the test register (address 7) sets each state bit written as 1.
- R10: `irq_o[i]` is high exactly when state bit i is set and enable bit i (address 5) is set.
- R11: If a hardware condition and a software clear hit the same state bit in one cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pad_i | input | 32 | Asynchronous pad levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 filter enable, 1 rising, 2 falling, 3 high, 4 low, 5 interrupt enable, 6 state clear, 7 test set |
| wr_data | input | 32 | Write data |
| data_in_o | output | 32 | Settled pin levels |
| intr_state_o | output | 32 | Pending interrupt state |
| irq_o | output | 32 | Per-pin interrupt lines |

## Verification
The bench first drives random pad words with every filter off. This tests the three-edge input latency apart from any filter effect. It then applies single-pin pulses one clock shorter than the filter window, and holds that are longer, to separate the ignore case from the accept case. Edge and level masks are tried one at a time against toggling pads, so a rising-edge mistake cannot hide behind a level condition. Clears are issued while a level persists to show that a hardware set wins. A long random mix of pad changes and writes, checked against a reference model on every clock, covers interactions between the conditions.

// File: rtl/gpin_pkg.sv
package gpin_pkg;

    parameter int unsigned PIN_W = 32;

    typedef enum logic [2:0] {
        REG_FILT  = 3'd0,
        REG_RISE  = 3'd1,
        REG_FALL  = 3'd2,
        REG_HIGH  = 3'd3,
        REG_LOW   = 3'd4,
        REG_IEN   = 3'd5,
        REG_STATE = 3'd6,
        REG_TEST  = 3'd7
    } gpin_reg_e;

    typedef struct packed {
        logic [PIN_W-1:0] rise;
        logic [PIN_W-1:0] fall;
        logic [PIN_W-1:0] high;
        logic [PIN_W-1:0] low;
    } gpin_trig_t;

    function automatic int unsigned cnt_width(input int unsigned cycles);
        return (cycles > 1) ? $clog2(cycles) : 1;
    endfunction

endpackage

// File: rtl/gpin_sync.sv
module gpin_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= pad_i;
            sync_o <= meta_q;
        end
    end
endmodule

// File: rtl/gpin_filter.sv
module gpin_filter #(
    parameter int unsigned W   = 32,
    parameter int unsigned CYC = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] sync_i,
    input  logic [W-1:0] filt_en_i,
    output logic [W-1:0] settled_o
);
    localparam int unsigned CW = gpin_pkg::cnt_width(CYC);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic [CW-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q        <= '0;
                settled_o[i] <= 1'b0;
            end else if (!filt_en_i[i]) begin
                cnt_q        <= '0;
                settled_o[i] <= sync_i[i];
            end else if (sync_i[i] == settled_o[i]) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q        <= '0;
                settled_o[i] <= sync_i[i];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpin_irq_core.sv
module gpin_irq_core
    import gpin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] settled_i,
    input  gpin_trig_t       trig_i,
    input  logic [PIN_W-1:0] ien_i,
    input  logic [PIN_W-1:0] clr_i,
    input  logic [PIN_W-1:0] tst_i,
    output logic [PIN_W-1:0] evt_o,
    output logic [PIN_W-1:0] state_o,
    output logic [PIN_W-1:0] irq_o
);
    logic [PIN_W-1:0] last_q;

    always_comb begin
        evt_o = (trig_i.rise & settled_i & ~last_q)
              | (trig_i.fall & ~settled_i & last_q)
              | (trig_i.high & settled_i)
              | (trig_i.low  & ~settled_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q  <= '0;
            state_o <= '0;
        end else begin
            last_q  <= settled_i;
            state_o <= (state_o & ~clr_i) | evt_o | tst_i;
        end
    end

    assign irq_o = state_o & ien_i;
endmodule

// File: rtl/gpin_irq_ctrl.sv
module gpin_irq_ctrl
    import gpin_pkg::*;
#(
    parameter int unsigned FILTER_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] pad_i,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic [31:0] data_in_o,
    output logic [31:0] intr_state_o,
    output logic [31:0] irq_o
);
    logic [PIN_W-1:0] sync_q;
    logic [PIN_W-1:0] filt_en_q;
    logic [PIN_W-1:0] ien_q;
    gpin_trig_t       trig_q;
    logic [PIN_W-1:0] clr_w;
    logic [PIN_W-1:0] tst_w;
    logic [PIN_W-1:0] evt;
    gpin_reg_e        sel;

    assign sel   = gpin_reg_e'(wr_addr);
    assign clr_w = (wr_en && sel == REG_STATE) ? wr_data : '0;
    assign tst_w = (wr_en && sel == REG_TEST)  ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_en_q <= '0;
            ien_q     <= '0;
            trig_q    <= '0;
        end else if (wr_en) begin
            case (sel)
                REG_FILT: filt_en_q   <= wr_data;
                REG_RISE: trig_q.rise <= wr_data;
                REG_FALL: trig_q.fall <= wr_data;
                REG_HIGH: trig_q.high <= wr_data;
                REG_LOW:  trig_q.low  <= wr_data;
                REG_IEN:  ien_q       <= wr_data;
                default:  ;
            endcase
        end
    end

    gpin_sync #(.W(PIN_W)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_i  (pad_i),
        .sync_o (sync_q)
    );

    gpin_filter #(.W(PIN_W), .CYC(FILTER_CYCLES)) u_filt (
        .clk       (clk),
        .rst       (rst),
        .sync_i    (sync_q),
        .filt_en_i (filt_en_q),
        .settled_o (data_in_o)
    );

    gpin_irq_core u_core (
        .clk       (clk),
        .rst       (rst),
        .settled_i (data_in_o),
        .trig_i    (trig_q),
        .ien_i     (ien_q),
        .clr_i     (clr_w),
        .tst_i     (tst_w),
        .evt_o     (evt),
        .state_o   (intr_state_o),
        .irq_o     (irq_o)
    );
endmodule

// File: rtl/gpin_irq_chk.sv
module gpin_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic [31:0] sync_q,
    input logic [31:0] filt_en,
    input logic [31:0] evt,
    input logic [31:0] data_in,
    input logic [31:0] intr_state,
    input logic [31:0] irq
);
    p_unfilt_follow_r2: assert property (@(posedge clk) disable iff (rst)
        ((data_in ^ $past(sync_q)) & ~$past(filt_en)) == '0);

    p_filter_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (($past(data_in) ^ data_in) & $past(filt_en) & (data_in ^ $past(sync_q))) == '0);

    p_event_sets_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (intr_state & $past(evt)) == $past(evt));

    p_clear_w1c_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd6) |=> (intr_state & $past(wr_data) & ~$past(evt)) == '0);

    p_test_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd7) |=> (intr_state & $past(wr_data)) == $past(wr_data));

    p_irq_needs_state_r10: assert property (@(posedge clk) disable iff (rst)
        (irq & ~intr_state) == '0);
endmodule

bind gpin_irq_ctrl gpin_irq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .sync_q     (sync_q),
    .filt_en    (filt_en_q),
    .evt        (evt),
    .data_in    (data_in_o),
    .intr_state (intr_state_o),
    .irq        (irq_o)
);

// File: tb/gpin_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpin_irq_ctrl_bench;
    localparam int FCYC = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pad_i = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] data_in_o, intr_state_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gpin_irq_ctrl #(.FILTER_CYCLES(FCYC)) u_gpin_irq_ctrl (
        .clk(clk), .rst(rst), .pad_i(pad_i), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .data_in_o(data_in_o), .intr_state_o(intr_state_o), .irq_o(irq_o)
    );

    // behavioural reference model
    bit [31:0] m_s1, m_s2, m_set, m_prev, m_state;
    bit [31:0] m_filt, m_rise, m_fall, m_high, m_low, m_ien;
    int        m_cnt [32];

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_set = 0; m_prev = 0; m_state = 0;
            m_filt = 0; m_rise = 0; m_fall = 0; m_high = 0; m_low = 0; m_ien = 0;
            foreach (m_cnt[k]) m_cnt[k] = 0;
        end else begin
            bit [31:0] ev, clr, tst, nset;
            ev = 0; clr = 0; tst = 0; nset = m_set;
            for (int i = 0; i < 32; i++) begin
                if (m_rise[i] && m_set[i] && !m_prev[i]) ev[i] = 1;
                if (m_fall[i] && !m_set[i] && m_prev[i]) ev[i] = 1;
                if (m_high[i] && m_set[i]) ev[i] = 1;
                if (m_low[i] && !m_set[i]) ev[i] = 1;
                if (!m_filt[i]) begin
                    nset[i] = m_s2[i];
                    m_cnt[i] = 0;
                end else if (m_s2[i] == m_set[i]) begin
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i] = m_cnt[i] + 1;
                    if (m_cnt[i] >= FCYC) begin
                        nset[i] = m_s2[i];
                        m_cnt[i] = 0;
                    end
                end
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_filt = wr_data;
                    3'd1: m_rise = wr_data;
                    3'd2: m_fall = wr_data;
                    3'd3: m_high = wr_data;
                    3'd4: m_low  = wr_data;
                    3'd5: m_ien  = wr_data;
                    3'd6: clr    = wr_data;
                    default: tst = wr_data;
                endcase
            end
            m_state = (m_state & ~clr) | ev | tst;
            m_prev = m_set;
            m_set  = nset;
            m_s2   = m_s1;
            m_s1   = pad_i;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R2 data_in", data_in_o, m_set);
            chk("R8 intr_state", intr_state_o, m_state);
            chk("R10 irq", irq_o, m_state & m_ien);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 data_in", data_in_o, 0);
        chk("R1 state", intr_state_o, 0);
        chk("R1 irq", irq_o, 0);
        rst = 0;
        @(negedge clk);
        chk("R1 state after reset", intr_state_o, 0);

        // R2: unfiltered random pads
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); pad_i = $urandom;
        end
        @(negedge clk); pad_i = 32'h0000_00F0;
        idle(3);
        chk("R2 three-edge latency", data_in_o, 32'h0000_00F0);
        pad_i = 0; idle(4);
        wr(3'd5, 32'hFFFF_FFFF);

        // R4 rising
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd1, 32'h0000_000F);
        pad_i = 32'h0000_0005; idle(5);
        chk("R4 rising sets", intr_state_o, 32'h0000_0005);
        pad_i = 0; idle(5);
        chk("R4 falling ignored by rise mask", intr_state_o, 32'h0000_0005);
        wr(3'd1, 0); wr(3'd6, 32'hFFFF_FFFF);

        // R5 falling
        pad_i = 32'h0000_0300; idle(5);
        wr(3'd2, 32'h0000_0F00);
        chk("R5 no fall yet", intr_state_o, 0);
        pad_i = 0; idle(5);
        chk("R5 falling sets", intr_state_o, 32'h0000_0300);
        wr(3'd2, 0); wr(3'd6, 32'hFFFF_FFFF);

        // R6 high level and R11 set wins over clear
        pad_i = 32'h0001_0000; idle(5);
        wr(3'd3, 32'h0001_0000);
        idle(1);
        wr(3'd6, 32'h0001_0000);
        chk("R11 level set beats clear", intr_state_o, 32'h0001_0000);
        chk("R6 high level", intr_state_o[16], 1);
        wr(3'd3, 0); wr(3'd6, 32'hFFFF_FFFF);
        chk("R8 clear after mask off", intr_state_o, 0);

        // R7 low level
        wr(3'd4, 32'h0000_0001);
        idle(1);
        chk("R7 low level", intr_state_o, 32'h0000_0001);
        wr(3'd4, 0); wr(3'd6, 32'hFFFF_FFFF);
        pad_i = 0; idle(3);

        // R9 test and R8 partial clear, R10 gating
        wr(3'd7, 32'hA5A5_0000);
        chk("R9 test sets", intr_state_o, 32'hA5A5_0000);
        wr(3'd5, 32'h00FF_0000);
        chk("R10 gated irq", irq_o, 32'h00A5_0000);
        wr(3'd6, 32'h8001_0000);
        chk("R8 partial clear", intr_state_o, 32'h25A4_0000);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);

        // R3 filter: short pulse ignored, long hold accepted
        wr(3'd0, 32'h0000_0001);
        wr(3'd1, 32'h0000_0001);
        pad_i[0] = 1; idle(FCYC - 1);
        pad_i[0] = 0; idle(2 * FCYC);
        chk("R3 short pulse ignored", data_in_o, 0);
        chk("R3 no edge from pulse", intr_state_o, 0);
        pad_i[0] = 1; idle(FCYC + 1);
        chk("R3 not yet accepted", data_in_o[0], 0);
        idle(1);
        chk("R3 accepted after window", data_in_o[0], 1);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) pad_i = $urandom;
            else if ($urandom_range(0, 1) == 0) pad_i[$urandom_range(0, 31)] ^= 1'b1;
            if ($urandom_range(0, 9) == 0) begin
                wr_en = 1; wr_addr = 3'($urandom_range(0, 7)); wr_data = $urandom;
            end else begin
                wr_en = 0;
            end
        end
        @(negedge clk); wr_en = 0;
        idle(4);
        finish_run();
    end
endmodule